// File: doc/BRIEF.md
# DAC Initialization and Update Sequencer

This block is the host-side controller for a 16-channel serial DAC. It does not shift bits itself: it hands complete 24-bit command frames, an 8-bit command byte followed by a 16-bit data word, to a separate serial shifter over a valid/ready handshake. A start pulse runs the bring-up sequence. The device is first reset, either by a timed pulse on a dedicated reset line or by a keyed reset command. After a settling gap, the block writes a fixed list of default dither settings and then the output-span code.

Once configured, the block is in run mode. A single-cycle update request carries a channel mask and a packed set of samples. Sample slot 0 belongs to the lowest selected channel, slot 1 to the next selected channel, and so on. The block writes the input register of each selected channel in ascending order. It then issues one load command carrying the mask, so that every selected output changes at the same moment. Reset pulse length and settling time are given in nanoseconds and converted to clock cycles, rounding up.

Top module: `dac_seq_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy_o`, `frm_valid_o`, `dac_rst_o` and `err_o` are all 0.
- R2: A start with `hw_rst_sel_i`=1 drives `dac_rst_o` high for exactly ceil(RST_NS/CLK_PERIOD_NS) cycles (13 at 8 ns), beginning in the cycle after the start. No frame is offered while the line is high.
- R3: A start with `hw_rst_sel_i`=0 never raises `dac_rst_o`. Its first frame is 0x701234: command byte 0x70, key 0x1234.
- R4: After the reset ends (falling edge of the reset line, or acceptance of the 0x70 frame), no frame is offered for exactly ceil(SETTLE_NS/CLK_PERIOD_NS) cycles (4 at 8 ns).
- R5: The configuration frames follow the reset, in this order: 0x51FFFF (all dither blocks powered down), 0x905555 and 0xA05555 (source word low then high; bit 2*ch set selects the first source for every channel), 0xC00000 and 0xD00000 (scale words low then high), 0xB00000 (no inversion), and last 0x40 with the span code in bits [2:0] of the data word.
- R6: An accepted update emits one frame per set mask bit, in ascending channel order. Bits [23:20] are 0x1, bits [19:16] are the channel number, and bits [15:0] hold the next unused sample slot, left-aligned in the 16-bit field.
- R7: After the channel frames, exactly one frame 0x30 is sent whose data is the mask. An empty mask produces only this frame, 0x300000.
- R8: A frame that is offered but not accepted stays offered, with unchanged data, in the next cycle.
- R9: `busy_o` is high from the cycle after an accepted start or update until the last frame of that sequence is accepted. It is low in the following cycle.
- R10: An update request made before the first configuration, or while `busy_o` is high, produces no frames and raises `err_o` for the cycle after the request.
- R11: A start pulse while `busy_o` is high is ignored: the ongoing sequence completes unchanged and no new sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse: run reset and configuration |
| hw_rst_sel_i | input | 1 | 1 = reset by pulse on dac_rst_o, 0 = keyed reset frame |
| span_code_i | input | SPW | Output span code, captured at start |
| upd_req_i | input | 1 | Pulse: request a simultaneous update |
| upd_mask_i | input | NCH | Channels to update, bit n = channel n |
| upd_samples_i | input | NCH*DW | Packed samples, slot k at bits [k*DW +: DW] |
| dac_rst_o | output | 1 | Hardware reset line to the DAC, active high |
| frm_valid_o | output | 1 | Frame offered to the shifter |
| frm_ready_i | input | 1 | Shifter accepts the offered frame |
| frm_data_o | output | 24 | Frame: command [23:16], data [15:0] |
| busy_o | output | 1 | A sequence is in progress |
| err_o | output | 1 | One-cycle flag: update request refused |

## Verification
The reset line rises in the cycle after the start edge, and the error flag appears in the cycle after the refused request. Both are sampled on the falling clock edge that follows that rising edge. The reset width and the settling gap are measured by counting falling edges on which the line is high, and then falling edges on which neither the line nor a valid frame is present, up to the first valid frame. Frames are recorded on the falling edge where valid meets the randomly driven ready, one rising edge before acceptance. The busy drop is therefore checked on the very next falling edge, and held frames are compared across consecutive falling edges.

// File: rtl/dac_seq_pkg.sv
// Package: shared command codes, configuration constants and sequencer states
// for the DAC initialization and update sequencer. The command byte values are
// fixed by the DAC's serial protocol.
package dac_seq_pkg;

    localparam logic [7:0]  CMD_KEYED_RST  = 8'h70;
    localparam logic [15:0] RST_KEY        = 16'h1234;
    localparam logic [7:0]  CMD_DITH_PWR   = 8'h51;
    localparam logic [7:0]  CMD_SRC_LO     = 8'h90;
    localparam logic [7:0]  CMD_SRC_HI     = 8'hA0;
    localparam logic [7:0]  CMD_SCL_LO     = 8'hC0;
    localparam logic [7:0]  CMD_SCL_HI     = 8'hD0;
    localparam logic [7:0]  CMD_INVERT     = 8'hB0;
    localparam logic [7:0]  CMD_SPAN       = 8'h40;
    localparam logic [3:0]  CMD_IN_REG_HI  = 4'h1;
    localparam logic [7:0]  CMD_LOAD_MASK  = 8'h30;

    // Index of the last configuration frame (the span write).
    localparam logic [2:0]  CFG_LAST       = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE,     // never configured
        S_HRST,     // hardware reset line held high
        S_SRST,     // keyed reset frame offered
        S_SETTLE,   // post-reset quiet time
        S_CFG,      // default configuration frames
        S_RUN,      // configured, waiting for work
        S_UCH,      // channel input-register frames
        S_ULD       // masked load frame
    } seq_state_t;

    // Default source word: two bits per channel, the lower bit set selects
    // the first dither source for every channel in the 8-channel half.
    function automatic logic [15:0] src_default();
        logic [15:0] w;
        w = '0;
        for (int i = 0; i < 8; i++) begin
            w[2*i] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
// Module: down-counting interval timer shared by the reset and settle phases.
// Assumes: a load always wins over a decrement; last_o marks the final cycle
// of an interval of load value cycles (load values are at least 1).
module dac_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    // Count register: load, else decrement toward zero while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // Final-cycle flag of the current interval.
    always_comb last_o = (cnt_q == W'(1));

endmodule

// File: rtl/dac_seq_lowbit.sv
// Module: finds the index of the lowest set bit of a vector (priority encoder).
// Assumes: result is don't-care (zero) when the vector is empty.
module dac_seq_lowbit #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);

    // Scan from the top so the lowest set bit is the one that remains.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/dac_seq_cfg_rom.sv
// Module: computes the default-configuration frame for a given step index.
// Assumes: step 6 is always the span write so the span lands after every
// dither setting; steps beyond 6 repeat the span frame.
module dac_seq_cfg_rom
    import dac_seq_pkg::*;
#(
    parameter int SPW = 3
) (
    input  logic [2:0]     idx_i,
    input  logic [SPW-1:0] span_i,
    output logic [23:0]    frame_o
);

    // Step-indexed frame selection.
    always_comb begin
        case (idx_i)
            3'd0:    frame_o = {CMD_DITH_PWR, 16'hFFFF};
            3'd1:    frame_o = {CMD_SRC_LO,   src_default()};
            3'd2:    frame_o = {CMD_SRC_HI,   src_default()};
            3'd3:    frame_o = {CMD_SCL_LO,   16'h0000};
            3'd4:    frame_o = {CMD_SCL_HI,   16'h0000};
            3'd5:    frame_o = {CMD_INVERT,   16'h0000};
            default: frame_o = {CMD_SPAN,     16'(span_i)};
        endcase
    end

endmodule

// File: rtl/dac_seq_ctrl.sv
// Module: top of the DAC initialization and update sequencer. Runs reset
// (pulse or keyed frame), waits the settle time, writes the configuration,
// then serves masked updates as per-channel writes plus one masked load.
// Assumes: NCH <= 16 and DW <= 16; the downstream shifter holds off via
// frm_ready_i; timings are converted to cycles rounding up.
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int NCH           = 16,
    parameter int DW            = 16,
    parameter int SPW           = 3,
    parameter int CLK_PERIOD_NS = 8,
    parameter int RST_NS        = 100,
    parameter int SETTLE_NS     = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               hw_rst_sel_i,
    input  logic [SPW-1:0]     span_code_i,
    input  logic               upd_req_i,
    input  logic [NCH-1:0]     upd_mask_i,
    input  logic [NCH*DW-1:0]  upd_samples_i,
    output logic               dac_rst_o,
    output logic               frm_valid_o,
    input  logic               frm_ready_i,
    output logic [23:0]        frm_data_o,
    output logic               busy_o,
    output logic               err_o
);

    localparam int RST_CYC = (RST_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int SET_CYC = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int MAX_CYC = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1;

    seq_state_t         st_q;
    logic [SPW-1:0]     span_q;
    logic [2:0]         cfg_idx_q;
    logic [NCH-1:0]     mask_q;
    logic [NCH-1:0]     rem_q;
    logic [NCH*DW-1:0]  samp_q;
    logic [CHW-1:0]     slot_q;
    logic               err_q;

    logic               fire;
    logic               start_ok;
    logic               upd_ok;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_dec;
    logic               tmr_last;
    logic [CHW-1:0]     pick_idx;
    logic [NCH-1:0]     rem_after;
    logic [23:0]        cfg_frame;
    logic [DW-1:0]      samp_arr [NCH];
    logic [15:0]        samp16;

    // Handshake and request qualification.
    always_comb begin
        fire     = frm_valid_o && frm_ready_i;
        start_ok = start_i && (st_q == S_IDLE || st_q == S_RUN);
        upd_ok   = upd_req_i && (st_q == S_RUN) && !start_i;
    end

    // Timer control: reset width on hardware start, settle after either reset.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start_ok && hw_rst_sel_i) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC);
        end else if ((st_q == S_HRST && tmr_last) || (st_q == S_SRST && fire)) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(SET_CYC);
        end
        tmr_dec = (st_q == S_HRST) || (st_q == S_SETTLE);
    end

    dac_seq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .dec_i  (tmr_dec),
        .last_o (tmr_last)
    );

    dac_seq_lowbit #(.N(NCH), .IW(CHW)) u_lowbit (
        .vec_i (rem_q),
        .idx_o (pick_idx)
    );

    dac_seq_cfg_rom #(.SPW(SPW)) u_cfg (
        .idx_i   (cfg_idx_q),
        .span_i  (span_q),
        .frame_o (cfg_frame)
    );

    // Unpack the captured sample set into addressable slots.
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        assign samp_arr[g] = samp_q[g*DW +: DW];
    end

    // Remaining mask with its lowest set bit cleared.
    always_comb rem_after = rem_q & (rem_q - NCH'(1));

    // Left-align the current sample in the 16-bit data field.
    always_comb samp16 = 16'(samp_arr[slot_q]) << (16 - DW);

    // Sequencer state and captured request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            span_q    <= '0;
            cfg_idx_q <= '0;
            mask_q    <= '0;
            rem_q     <= '0;
            samp_q    <= '0;
            slot_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= upd_req_i && !upd_ok;
            case (st_q)
                S_IDLE, S_RUN: begin
                    if (start_ok) begin
                        span_q    <= span_code_i;
                        cfg_idx_q <= '0;
                        st_q      <= hw_rst_sel_i ? S_HRST : S_SRST;
                    end else if (upd_ok) begin
                        mask_q <= upd_mask_i;
                        rem_q  <= upd_mask_i;
                        samp_q <= upd_samples_i;
                        slot_q <= '0;
                        st_q   <= (|upd_mask_i) ? S_UCH : S_ULD;
                    end
                end
                S_HRST: begin
                    if (tmr_last) st_q <= S_SETTLE;
                end
                S_SRST: begin
                    if (fire) st_q <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (tmr_last) st_q <= S_CFG;
                end
                S_CFG: begin
                    if (fire) begin
                        if (cfg_idx_q == CFG_LAST) st_q <= S_RUN;
                        else                       cfg_idx_q <= cfg_idx_q + 3'd1;
                    end
                end
                S_UCH: begin
                    if (fire) begin
                        rem_q  <= rem_after;
                        slot_q <= slot_q + CHW'(1);
                        if (rem_after == '0) st_q <= S_ULD;
                    end
                end
                S_ULD: begin
                    if (fire) st_q <= S_RUN;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Status outputs decoded from the state.
    always_comb begin
        dac_rst_o   = (st_q == S_HRST);
        frm_valid_o = (st_q == S_SRST) || (st_q == S_CFG) ||
                      (st_q == S_UCH)  || (st_q == S_ULD);
        busy_o      = !(st_q == S_IDLE || st_q == S_RUN);
        err_o       = err_q;
    end

    // Frame content for the offered frame.
    always_comb begin
        case (st_q)
            S_SRST:  frm_data_o = {CMD_KEYED_RST, RST_KEY};
            S_CFG:   frm_data_o = cfg_frame;
            S_UCH:   frm_data_o = {CMD_IN_REG_HI, 4'(pick_idx), samp16};
            S_ULD:   frm_data_o = {CMD_LOAD_MASK, 16'(mask_q)};
            default: frm_data_o = '0;
        endcase
    end

endmodule

// File: rtl/dac_seq_ctrl_chk.sv
// Module: protocol checker for dac_seq_ctrl, attached by bind. Observes ports
// only; assumes the reset width parameters match the bound instance.
module dac_seq_ctrl_chk #(
    parameter int CLK_PERIOD_NS = 8,
    parameter int RST_NS        = 100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_req_i,
    input logic        dac_rst_o,
    input logic        frm_valid_o,
    input logic        frm_ready_i,
    input logic [23:0] frm_data_o,
    input logic        busy_o,
    input logic        err_o
);

    localparam int RST_CYC = (RST_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

    logic [15:0] hi_cnt_q;

    // Length of the current high run of the reset line, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_cnt_q <= '0;
        else if (!dac_rst_o)         hi_cnt_q <= '0;
        else if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 16'd1;
    end

    a_r8_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o && !frm_ready_i |=> frm_valid_o && $stable(frm_data_o));

    a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o |-> busy_o);

    a_r2_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dac_rst_o |-> busy_o && !frm_valid_o);

    a_r2_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_rst_o) |-> hi_cnt_q >= 16'(RST_CYC));

    a_r3_reset_key: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid_o && frm_data_o[23:16] == 8'h70 |-> frm_data_o[15:0] == 16'h1234);

    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(upd_req_i));

endmodule

bind dac_seq_ctrl dac_seq_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .RST_NS        (RST_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_req_i   (upd_req_i),
    .dac_rst_o   (dac_rst_o),
    .frm_valid_o (frm_valid_o),
    .frm_ready_i (frm_ready_i),
    .frm_data_o  (frm_data_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/dac_seq_ctrl_tb_top.sv
// Bench: random ready back-pressure and random update sets mixed with directed
// corner cases; expected frame lists come from bench functions.
module dac_seq_ctrl_tb_top;

    localparam int NCH = 16;
    localparam int DW  = 16;
    localparam int SPW = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start_i;
    logic               hw_rst_sel_i;
    logic [SPW-1:0]     span_code_i;
    logic               upd_req_i;
    logic [NCH-1:0]     upd_mask_i;
    logic [NCH*DW-1:0]  upd_samples_i;
    logic               dac_rst_o;
    logic               frm_valid_o;
    logic               frm_ready_i;
    logic [23:0]        frm_data_o;
    logic               busy_o;
    logic               err_o;

    always #4 clk = ~clk;

    dac_seq_ctrl #(
        .NCH(NCH), .DW(DW), .SPW(SPW),
        .CLK_PERIOD_NS(8), .RST_NS(100), .SETTLE_NS(25)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hw_rst_sel_i(hw_rst_sel_i),
        .span_code_i(span_code_i), .upd_req_i(upd_req_i), .upd_mask_i(upd_mask_i),
        .upd_samples_i(upd_samples_i), .dac_rst_o(dac_rst_o), .frm_valid_o(frm_valid_o),
        .frm_ready_i(frm_ready_i), .frm_data_o(frm_data_o), .busy_o(busy_o), .err_o(err_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [23:0] got_q [$];
    int          rst_run = 0;
    int          rst_len = 0;
    int          gap = 0;
    int          gap_meas = -1;
    bit          gap_on = 1'b0;
    bit          prev_v = 1'b0;
    bit          prev_r = 1'b0;
    logic [23:0] prev_d = '0;
    bit          exp_free = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor on falling edges: hold rule, busy drop, reset width, settle gap,
    // random ready and frame capture.
    always @(negedge clk) begin
        if (rst_n) begin
            bit r;
            if (prev_v && !prev_r)
                chk(frm_valid_o && frm_data_o == prev_d, "R8 held frame",
                    {7'd0, frm_valid_o, frm_data_o}, {8'h01, prev_d});
            if (exp_free) begin
                chk(!busy_o, "R9 busy after last frame", 32'(busy_o), 32'd0);
                exp_free = 1'b0;
            end
            if (dac_rst_o) rst_run++;
            else if (rst_run != 0) begin
                rst_len = rst_run; rst_run = 0; gap_on = 1'b1; gap = 0;
            end
            if (gap_on) begin
                if (frm_valid_o) begin gap_meas = gap; gap_on = 1'b0; end
                else gap++;
            end
            r = ($urandom % 4) != 0;
            if (frm_valid_o && r) begin
                got_q.push_back(frm_data_o);
                if (frm_data_o[23:16] == 8'h70) begin gap_on = 1'b1; gap = 0; end
                if (frm_data_o[23:16] == 8'h40 || frm_data_o[23:16] == 8'h30) exp_free = 1'b1;
            end
            prev_v = frm_valid_o; prev_r = r; prev_d = frm_data_o;
            frm_ready_i = r;
        end
    end

    function automatic void cfg_list(input logic [SPW-1:0] span, ref logic [23:0] q[$]);
        q.push_back(24'h51FFFF);
        q.push_back(24'h905555);
        q.push_back(24'hA05555);
        q.push_back(24'hC00000);
        q.push_back(24'hD00000);
        q.push_back(24'hB00000);
        q.push_back({8'h40, 16'(span)});
    endfunction

    function automatic void upd_list(input logic [NCH-1:0] m, input logic [NCH*DW-1:0] s,
                                     ref logic [23:0] q[$]);
        int k = 0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (m[ch]) begin
                q.push_back({4'h1, 4'(ch), s[k*DW +: DW]});
                k++;
            end
        end
        q.push_back({8'h30, 16'(m)});
    endfunction

    task automatic expect_frames(input logic [23:0] exp[$], input string req);
        int n;
        chk(got_q.size() == exp.size(), req, 32'(got_q.size()), 32'(exp.size()));
        n = (got_q.size() < exp.size()) ? got_q.size() : exp.size();
        for (int i = 0; i < n; i++) chk(got_q[i] == exp[i], req, 32'(got_q[i]), 32'(exp[i]));
        got_q.delete();
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy_o && k < 5000) begin @(negedge clk); k++; end
        chk(!busy_o, req, 32'(busy_o), 32'd0);
    endtask

    task automatic do_start(input bit hw, input logic [SPW-1:0] span);
        @(negedge clk);
        hw_rst_sel_i = hw; span_code_i = span; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R9 busy after start", 32'(busy_o), 32'd1);
    endtask

    task automatic do_update(input logic [NCH-1:0] m, input logic [NCH*DW-1:0] s,
                             input string req);
        logic [23:0] e [$];
        @(negedge clk);
        upd_mask_i = m; upd_samples_i = s; upd_req_i = 1'b1;
        @(negedge clk);
        upd_req_i = 1'b0;
        chk(!err_o, "R10 accepted update no error", 32'(err_o), 32'd0);
        wait_idle("R9 update completes");
        upd_list(m, s, e);
        expect_frames(e, req);
    endtask

    function automatic logic [NCH*DW-1:0] rand_samples();
        logic [NCH*DW-1:0] s;
        for (int i = 0; i < NCH; i++) s[i*DW +: DW] = DW'($urandom);
        return s;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_report();
    end

    // Directed and random stimulus.
    initial begin
        logic [23:0] e [$];
        logic [NCH*DW-1:0] s1;
        void'($urandom(32'd20240));
        rst_n = 1'b0; start_i = 1'b0; hw_rst_sel_i = 1'b0; span_code_i = '0;
        upd_req_i = 1'b0; upd_mask_i = '0; upd_samples_i = '0; frm_ready_i = 1'b0;
        repeat (5) @(negedge clk);
        chk({busy_o, frm_valid_o, dac_rst_o, err_o} == 4'b0, "R1 in reset",
            32'({busy_o, frm_valid_o, dac_rst_o, err_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, frm_valid_o, dac_rst_o, err_o} == 4'b0, "R1 after reset",
            32'({busy_o, frm_valid_o, dac_rst_o, err_o}), 32'd0);

        // R10: update before any configuration.
        upd_mask_i = 16'h0003; upd_req_i = 1'b1;
        @(negedge clk);
        upd_req_i = 1'b0;
        chk(err_o, "R10 err before init", 32'(err_o), 32'd1);
        @(negedge clk);
        chk(!err_o, "R10 err is one cycle", 32'(err_o), 32'd0);
        repeat (5) @(negedge clk);
        chk(got_q.size() == 0 && !busy_o, "R10 no frames before init", 32'(got_q.size()), 32'd0);

        // R2, R4, R5: hardware reset path.
        rst_len = 0; gap_meas = -1;
        do_start(1'b1, 3'd3);
        chk(dac_rst_o, "R2 reset line high after start", 32'(dac_rst_o), 32'd1);
        wait_idle("R9 init completes");
        chk(rst_len == 13, "R2 reset width", 32'(rst_len), 32'd13);
        chk(gap_meas == 4, "R4 settle after pulse", 32'(gap_meas), 32'd4);
        e.delete(); cfg_list(3'd3, e);
        expect_frames(e, "R5 config order hw");

        // R3, R4, R5: keyed reset path.
        rst_len = 0; gap_meas = -1;
        do_start(1'b0, 3'd6);
        wait_idle("R9 init completes");
        chk(rst_len == 0, "R3 no reset pulse", 32'(rst_len), 32'd0);
        chk(gap_meas == 4, "R4 settle after key frame", 32'(gap_meas), 32'd4);
        e.delete(); e.push_back(24'h701234); cfg_list(3'd6, e);
        expect_frames(e, "R3 R5 keyed reset and config");

        // R6, R7: directed masks.
        do_update(16'h0001, rand_samples(), "R6 lowest channel");
        do_update(16'h8000, rand_samples(), "R6 highest channel");
        do_update(16'hFFFF, rand_samples(), "R6 all channels");
        do_update(16'h0000, rand_samples(), "R7 empty mask");
        do_update(16'h00A5, rand_samples(), "R6 R7 sparse mask");
        for (int i = 0; i < 20; i++)
            do_update(NCH'($urandom), rand_samples(), "R6 R7 random update");

        // R10, R11: requests while busy.
        s1 = rand_samples();
        @(negedge clk);
        upd_mask_i = 16'hFFFF; upd_samples_i = s1; upd_req_i = 1'b1;
        @(negedge clk);
        upd_mask_i = 16'h0001; upd_req_i = 1'b1;
        @(negedge clk);
        upd_req_i = 1'b0;
        chk(err_o, "R10 err while busy", 32'(err_o), 32'd1);
        hw_rst_sel_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!dac_rst_o, "R11 start while busy ignored", 32'(dac_rst_o), 32'd0);
        wait_idle("R9 busy update completes");
        repeat (30) @(negedge clk);
        chk(!busy_o && !dac_rst_o, "R11 no restart after busy start", 32'(busy_o), 32'd0);
        e.delete(); upd_list(16'hFFFF, s1, e);
        expect_frames(e, "R10 R11 only first update sent");

        do_update(16'h4242, rand_samples(), "R6 update after refusals");
        finish_report();
    end

endmodule